// File: doc/BRIEF.md
# Double-Buffered Drum Read Controller

This block sits between a rotating storage drum and a host computer during a read. Once started with a word count, it takes data words from the drum into one of two 32-word buffers. When that buffer is full, the drum carries on into the other buffer while the host empties the first one, one word per request/acknowledge handshake. The two buffers keep swapping roles until the last addressed word has come off the drum. A final buffer that holds fewer than 32 words is handed over as if it were full. The host then drains it up to the last addressed word.

Each drum word is checked for odd parity. A failure raises an interrupt with a parity status code at once. That interrupt runs alongside the word handshakes, so no data word is lost. The host may fall behind, so that a buffer is still occupied when the drum needs it. In that case the controller lowers its drum enable and waits whole revolutions. It resumes at the first revolution index that finds the buffer free, picking up at the same word. Each such stall counts once in a saturating 8-bit counter. When the last word has been delivered, a completion interrupt reports normal or error status. Acknowledging it raises the ready-for-function line.

Top module: `drum_rd_ctrl`

## Requirements
- R1: After reset, drum_go, host_req and irq are 0, fn_ready is 1 and ovr_count is 0.
- R2: Drum words reach host_data in the order the drum delivered them, each exactly once. host_req stays 1 and host_data stays unchanged until host_ack is sampled high, and host_req is 0 in the cycle after that.
- R3: When a buffer fills and the other buffer is empty, the drum side goes on into the other buffer without dropping drum_go. A 64-word read with a host that keeps up therefore never pauses.
- R4: drum_go falls right after the last addressed word is taken. A short final buffer (word count not a multiple of 32) is still delivered, and exactly word_count words reach the host.
- R5: Odd parity covers drum_data together with drum_par: the XOR of all those bits must be 1. A word that fails is still stored. If no interrupt is up, irq rises with irq_status = 3'b010 on the same edge that takes the word.
- R6: Parity interrupts do not stall the data handshake. Parity errors that occur while a parity interrupt is waiting merge into one interrupt.
- R7: If a buffer fills while the other is still held for the host, drum_go drops and ovr_count increments by one for that occurrence, however many revolutions pass. Reading resumes on the first rev_index pulse that finds the needed buffer empty.
- R8: ovr_count saturates at 255, never decreases during a read, and is cleared when a read starts.
- R9: After the host acknowledges the last word, a completion interrupt is raised with irq_status = 3'b001 if the read saw no parity error and no overrun. Otherwise it carries 3'b101. It waits behind a parity interrupt that is still pending.
- R10: irq_ack while irq is 1 clears irq on that edge. fn_ready goes to 0 when a read starts and returns to 1 only on the acknowledge of a completion interrupt.
- R11: start is taken only while fn_ready is 1, irq is 0 and word_count is nonzero. A start pulse during a read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a read of word_count words |
| word_count | input | CNT_W | Number of addressed words |
| drum_valid | input | 1 | Drum word present this cycle |
| drum_data | input | WORD_W | Drum data word |
| drum_par | input | 1 | Drum parity bit (odd over data and this bit) |
| rev_index | input | 1 | Once-per-revolution index pulse |
| drum_go | output | 1 | Drum side may deliver words |
| host_req | output | 1 | Data word waiting for the host |
| host_data | output | WORD_W | Data word to the host |
| host_ack | input | 1 | Host takes the presented word |
| irq | output | 1 | Interrupt to the host |
| irq_status | output | 3 | Status code carried with irq |
| irq_ack | input | 1 | Host acknowledges the interrupt |
| fn_ready | output | 1 | Ready for the next function |
| ovr_count | output | OVR_W | Saturating overrun count |

## Verification
A parity failure on a drum word can land on the same edge as a host acknowledge, and both can meet an interrupt acknowledge. The interrupt path and the data path then act in one cycle. The bench provokes this with random word gaps, random host and interrupt acknowledge delays, and injected parity faults at a few percent. It judges the outcome by comparing every delivered word with the expected stream and by the final word count. It also checks that a parity interrupt appeared exactly when faults were injected, and that the completion code matches. Overrun and the last-word flush can also coincide with a busy host. A hold mode that acknowledges only while the drum is paused provokes those cases, and the overrun count is compared with the drum_go pauses the bench observed.

// File: rtl/drum_rd_pkg.sv
package drum_rd_pkg;
  localparam logic [2:0] ST_PARITY   = 3'b010;
  localparam logic [2:0] ST_DONE     = 3'b001;
  localparam logic [2:0] ST_DONE_ERR = 3'b101;

  typedef enum logic [1:0] {H_IDLE, H_LOAD, H_WAIT} host_st_t;
endpackage

// File: rtl/dbuf_mem.sv
module dbuf_mem #(
  parameter int W  = 30,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  q
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q <= mem[raddr];
  end
endmodule

// File: rtl/drum_fill.sv
module drum_fill #(
  parameter int WORD_W = 30,
  parameter int DEPTH  = 32,
  parameter int CNT_W  = 16,
  parameter int OVR_W  = 8,
  localparam int IDXW  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_acc,
  input  logic [CNT_W-1:0]  word_count,
  input  logic              drum_valid,
  input  logic [WORD_W-1:0] drum_data,
  input  logic              drum_par,
  input  logic              rev_index,
  input  logic [1:0]        full,
  output logic              drum_go,
  output logic              we,
  output logic [IDXW:0]     waddr,
  output logic [WORD_W-1:0] wdata,
  output logic              fill_evt,
  output logic              fill_buf,
  output logic [IDXW:0]     fill_len,
  output logic              fill_last,
  output logic              par_err,
  output logic              ovr_evt,
  output logic [OVR_W-1:0]  ovr_cnt
);
  logic             wbuf, stalled;
  logic [IDXW-1:0]  widx;
  logic [CNT_W-1:0] rem;
  logic             acc, last_w, end_buf;

  assign acc       = drum_valid && drum_go;
  assign last_w    = (rem == CNT_W'(1));
  assign end_buf   = (widx == IDXW'(DEPTH - 1));
  assign we        = acc;
  assign waddr     = {wbuf, widx};
  assign wdata     = drum_data;
  assign par_err   = acc && ~^{drum_data, drum_par};
  assign fill_evt  = acc && (last_w || end_buf);
  assign fill_buf  = wbuf;
  assign fill_len  = {1'b0, widx} + 1'b1;
  assign fill_last = last_w;
  assign ovr_evt   = acc && end_buf && !last_w && full[~wbuf];

  always_ff @(posedge clk) begin
    if (rst) begin
      drum_go <= 1'b0;
      stalled <= 1'b0;
      wbuf    <= 1'b0;
      widx    <= '0;
      rem     <= '0;
      ovr_cnt <= '0;
    end else if (start_acc) begin
      drum_go <= 1'b1;
      stalled <= 1'b0;
      wbuf    <= 1'b0;
      widx    <= '0;
      rem     <= word_count;
      ovr_cnt <= '0;
    end else if (acc) begin
      rem <= rem - 1'b1;
      if (last_w) begin
        drum_go <= 1'b0;
        widx    <= '0;
      end else if (end_buf) begin
        widx <= '0;
        wbuf <= ~wbuf;
        if (full[~wbuf]) begin
          drum_go <= 1'b0;
          stalled <= 1'b1;
          if (ovr_cnt != {OVR_W{1'b1}}) ovr_cnt <= ovr_cnt + 1'b1;
        end
      end else begin
        widx <= widx + 1'b1;
      end
    end else if (stalled && rev_index && !full[wbuf]) begin
      drum_go <= 1'b1;
      stalled <= 1'b0;
    end
  end

  // R7
  ovr_stop_chk: assert property (@(posedge clk) disable iff (rst)
    ovr_evt |=> (!drum_go && ovr_cnt != '0));

  // R8
  ovr_mono_chk: assert property (@(posedge clk) disable iff (rst)
    !start_acc |=> (ovr_cnt >= $past(ovr_cnt)));
endmodule

// File: rtl/host_drain.sv
module host_drain
  import drum_rd_pkg::*;
#(
  parameter int WORD_W = 30,
  parameter int DEPTH  = 32,
  localparam int IDXW  = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_acc,
  input  logic [1:0]           full,
  input  logic [1:0][IDXW:0]   buf_len,
  input  logic [1:0]           buf_last,
  input  logic [WORD_W-1:0]    mem_q,
  input  logic                 host_ack,
  output logic [IDXW:0]        raddr,
  output logic                 host_req,
  output logic [WORD_W-1:0]    host_data,
  output logic                 drain_evt,
  output logic                 drain_buf,
  output logic                 op_done
);
  host_st_t        st;
  logic            rbuf;
  logic [IDXW-1:0] ridx;
  logic            at_end;

  assign raddr     = {rbuf, ridx};
  assign at_end    = (({1'b0, ridx} + 1'b1) == buf_len[rbuf]);
  assign drain_evt = (st == H_WAIT) && host_ack && at_end;
  assign drain_buf = rbuf;
  assign op_done   = drain_evt && buf_last[rbuf];

  always_ff @(posedge clk) begin
    if (rst || start_acc) begin
      st       <= H_IDLE;
      rbuf     <= 1'b0;
      ridx     <= '0;
      host_req <= 1'b0;
      if (rst) host_data <= '0;
    end else begin
      unique case (st)
        H_IDLE: if (full[rbuf]) st <= H_LOAD;
        H_LOAD: begin
          host_data <= mem_q;
          host_req  <= 1'b1;
          st        <= H_WAIT;
        end
        H_WAIT: if (host_ack) begin
          host_req <= 1'b0;
          st       <= H_IDLE;
          if (at_end) begin
            ridx <= '0;
            rbuf <= ~rbuf;
          end else begin
            ridx <= ridx + 1'b1;
          end
        end
        default: st <= H_IDLE;
      endcase
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (host_req && !host_ack) |=> (host_req && $stable(host_data)));

  // R2
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (host_req && host_ack) |=> !host_req);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import drum_rd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_acc,
  input  logic       par_err,
  input  logic       ovr_evt,
  input  logic       op_done,
  input  logic       irq_ack,
  output logic       irq,
  output logic [2:0] irq_status,
  output logic       fn_ready
);
  logic par_pend, done_pend, err_seen;
  logic par_p, done_p;

  assign par_p  = par_pend | par_err;
  assign done_p = done_pend | op_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq        <= 1'b0;
      irq_status <= '0;
      fn_ready   <= 1'b1;
      par_pend   <= 1'b0;
      done_pend  <= 1'b0;
      err_seen   <= 1'b0;
    end else if (start_acc) begin
      fn_ready  <= 1'b0;
      par_pend  <= 1'b0;
      done_pend <= 1'b0;
      err_seen  <= 1'b0;
    end else begin
      if (par_err || ovr_evt) err_seen <= 1'b1;
      if (irq) begin
        par_pend  <= par_p;
        done_pend <= done_p;
        if (irq_ack) begin
          irq <= 1'b0;
          if (irq_status[0]) fn_ready <= 1'b1;
        end
      end else if (par_p) begin
        irq        <= 1'b1;
        irq_status <= ST_PARITY;
        par_pend   <= 1'b0;
        done_pend  <= done_p;
      end else if (done_p) begin
        irq        <= 1'b1;
        irq_status <= err_seen ? ST_DONE_ERR : ST_DONE;
        done_pend  <= 1'b0;
      end
    end
  end

  // R5
  par_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (par_err && !irq) |=> (irq && irq_status == ST_PARITY));

  // R10
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && irq_ack) |=> !irq);

  // R10
  ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fn_ready) |-> $past(irq_ack));
endmodule

// File: rtl/drum_rd_ctrl.sv
module drum_rd_ctrl #(
  parameter int WORD_W = 30,
  parameter int DEPTH  = 32,
  parameter int CNT_W  = 16,
  parameter int OVR_W  = 8,
  localparam int IDXW  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  word_count,
  input  logic              drum_valid,
  input  logic [WORD_W-1:0] drum_data,
  input  logic              drum_par,
  input  logic              rev_index,
  output logic              drum_go,
  output logic              host_req,
  output logic [WORD_W-1:0] host_data,
  input  logic              host_ack,
  output logic              irq,
  output logic [2:0]        irq_status,
  input  logic              irq_ack,
  output logic              fn_ready,
  output logic [OVR_W-1:0]  ovr_count
);
  logic                start_acc;
  logic [1:0]          full, buf_last;
  logic [1:0][IDXW:0]  buf_len;
  logic                we, fill_evt, fill_buf, fill_last, par_err, ovr_evt;
  logic [IDXW:0]       waddr, raddr, fill_len;
  logic [WORD_W-1:0]   wdata, mem_q;
  logic                drain_evt, drain_buf, op_done;

  assign start_acc = start && fn_ready && !irq && (word_count != '0);

  for (genvar b = 0; b < 2; b++) begin : g_buf
    logic          f_q, l_q;
    logic [IDXW:0] n_q;
    always_ff @(posedge clk) begin
      if (rst || start_acc) begin
        f_q <= 1'b0;
        l_q <= 1'b0;
        n_q <= '0;
      end else if (fill_evt && fill_buf == 1'(b)) begin
        f_q <= 1'b1;
        l_q <= fill_last;
        n_q <= fill_len;
      end else if (drain_evt && drain_buf == 1'(b)) begin
        f_q <= 1'b0;
      end
    end
    assign full[b]     = f_q;
    assign buf_last[b] = l_q;
    assign buf_len[b]  = n_q;
  end

  drum_fill #(.WORD_W(WORD_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .OVR_W(OVR_W)) u_fill (
    .clk(clk), .rst(rst), .start_acc(start_acc), .word_count(word_count),
    .drum_valid(drum_valid), .drum_data(drum_data), .drum_par(drum_par),
    .rev_index(rev_index), .full(full), .drum_go(drum_go), .we(we),
    .waddr(waddr), .wdata(wdata), .fill_evt(fill_evt), .fill_buf(fill_buf),
    .fill_len(fill_len), .fill_last(fill_last), .par_err(par_err),
    .ovr_evt(ovr_evt), .ovr_cnt(ovr_count)
  );

  dbuf_mem #(.W(WORD_W), .AW(IDXW + 1)) u_mem (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata), .raddr(raddr), .q(mem_q)
  );

  host_drain #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_drain (
    .clk(clk), .rst(rst), .start_acc(start_acc), .full(full),
    .buf_len(buf_len), .buf_last(buf_last), .mem_q(mem_q),
    .host_ack(host_ack), .raddr(raddr), .host_req(host_req),
    .host_data(host_data), .drain_evt(drain_evt), .drain_buf(drain_buf),
    .op_done(op_done)
  );

  irq_ctrl u_irq (
    .clk(clk), .rst(rst), .start_acc(start_acc), .par_err(par_err),
    .ovr_evt(ovr_evt), .op_done(op_done), .irq_ack(irq_ack), .irq(irq),
    .irq_status(irq_status), .fn_ready(fn_ready)
  );

  // R4
  last_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_evt && fill_last) |=> !drum_go);

  // R11
  busy_go_chk: assert property (@(posedge clk) disable iff (rst)
    drum_go |-> !fn_ready);
endmodule

// File: tb/drum_rd_ctrl_bench.sv
module drum_rd_ctrl_bench;
  localparam int W     = 30;
  localparam int CW    = 16;
  localparam int REV   = 64;
  localparam int LIMIT = 190000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [CW-1:0] word_count = '0;
  logic          drum_valid = 1'b0;
  logic [W-1:0]  drum_data = '0;
  logic          drum_par = 1'b0;
  logic          rev_index = 1'b0;
  logic          drum_go, host_req, irq, fn_ready;
  logic [W-1:0]  host_data;
  logic          host_ack = 1'b0;
  logic [2:0]    irq_status;
  logic          irq_ack = 1'b0;
  logic [7:0]    ovr_count;

  always #2 clk = ~clk;

  drum_rd_ctrl u_drum_rd_ctrl (
    .clk(clk), .rst(rst), .start(start), .word_count(word_count),
    .drum_valid(drum_valid), .drum_data(drum_data), .drum_par(drum_par),
    .rev_index(rev_index), .drum_go(drum_go), .host_req(host_req),
    .host_data(host_data), .host_ack(host_ack), .irq(irq),
    .irq_status(irq_status), .irq_ack(irq_ack), .fn_ready(fn_ready),
    .ovr_count(ovr_count)
  );

  int n_chk = 0, n_bad = 0, cycles = 0;
  int opid = 0, op_n = 0, sent = 0, got = 0, stalls = 0, bad = 0, saw_par = 0;
  int host_slow = 0, err_pct = 0, force_bad = -1;
  bit hold_mode = 0, op_active = 0, irq_hold = 0, done_seen = 0, prev_go = 0, par_next = 0;
  logic [2:0] done_status = '0;

  function automatic logic [W-1:0] word_of(int id, int k);
    logic [31:0] h;
    h = (32'(id) * 32'h9E3779B1) ^ (32'(k) * 32'h85EBCA6B) ^ 32'h5A5A1234;
    return h[W-1:0];
  endfunction

  function automatic logic [2:0] exp_done(bit err);
    return err ? 3'b101 : 3'b001;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_bench();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic step();
    logic [W-1:0] d;
    logic p;
    @(negedge clk);
    cycles++;
    if (cycles > LIMIT) begin
      chk(0, "watchdog", cycles, LIMIT);
      finish_bench();
    end
    rev_index = (cycles % REV) == 0;
    // parity interrupt raised on the capturing edge (R5)
    if (par_next) begin
      chk(irq === 1'b1 && irq_status === 3'b010, "R5 immediate parity irq",
          {irq, irq_status}, 4'b1010);
      par_next = 0;
      irq_hold = 0;
    end
    if (op_active && prev_go && !drum_go && sent < op_n) stalls++;
    prev_go = drum_go;
    // drum model
    drum_valid = 1'b0;
    if (op_active && drum_go && sent < op_n && ($urandom % 4) != 0) begin
      d = word_of(opid, sent);
      p = ~^d;
      if (sent == force_bad || ($urandom % 100) < err_pct) begin
        p = ~p;
        bad++;
        if (sent == force_bad) par_next = 1;
      end
      drum_data = d;
      drum_par = p;
      drum_valid = 1'b1;
      sent++;
    end
    // host model
    if (host_ack) host_ack = 1'b0;
    else if (host_req) begin
      if (hold_mode ? (!drum_go || sent == op_n) : (($urandom % (host_slow + 1)) == 0)) begin
        host_ack = 1'b1;
        chk(host_data === word_of(opid, got), "R2 word order", host_data, word_of(opid, got));
        got++;
      end
    end
    // interrupt model
    if (irq_ack) irq_ack = 1'b0;
    else if (irq && !irq_hold && ($urandom % 3) == 0) begin
      irq_ack = 1'b1;
      if (irq_status == 3'b010) saw_par++;
      else begin
        done_seen = 1;
        done_status = irq_status;
      end
    end
  endtask

  task automatic run_op(int n, int slow, bit hold, int epct, int fbad, bit poke, int exp_ovr);
    int exp_o;
    opid++;
    op_n = n; host_slow = slow; hold_mode = hold; err_pct = epct; force_bad = fbad;
    sent = 0; got = 0; stalls = 0; bad = 0; saw_par = 0; done_seen = 0;
    word_count = CW'(n);
    start = 1'b1;
    op_active = 1;
    step();
    start = 1'b0;
    chk(fn_ready === 1'b0, "R10 fn_ready low in read", fn_ready, 0);
    if (poke) begin
      repeat (10) step();
      word_count = CW'(5);
      start = 1'b1;
      step();
      start = 1'b0;
      word_count = CW'(n);
    end
    while (!done_seen) step();
    step();
    chk(fn_ready === 1'b1 && irq === 1'b0, "R10 ready after completion ack", {fn_ready, irq}, 2'b10);
    chk(got == n, poke ? "R11 busy start ignored" : "R4 word total", got, n);
    chk(sent == n, "R4 drum words taken", sent, n);
    chk(done_status === exp_done(bad > 0 || stalls > 0), "R9 completion status",
        done_status, exp_done(bad > 0 || stalls > 0));
    chk((saw_par > 0) == (bad > 0), "R6 parity irq iff faults", saw_par, bad);
    exp_o = (exp_ovr >= 0) ? exp_ovr : ((stalls > 255) ? 255 : stalls);
    chk(ovr_count == 8'(exp_o), "R7 overrun count", ovr_count, exp_o);
    op_active = 0;
    irq_hold = 0;
    force_bad = -1;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step();
    chk(drum_go === 1'b0 && host_req === 1'b0 && irq === 1'b0, "R1 reset outputs",
        {drum_go, host_req, irq}, 0);
    chk(fn_ready === 1'b1 && ovr_count === 8'd0, "R1 reset ready/count", {fn_ready, ovr_count}, 9'h100);
    // R11: zero count start ignored
    word_count = '0;
    start = 1'b1;
    step();
    start = 1'b0;
    step();
    chk(fn_ready === 1'b1 && drum_go === 1'b0, "R11 zero count ignored", {fn_ready, drum_go}, 2'b10);
    // R3: two full buffers, fast host, no pause
    run_op(64, 0, 0, 0, -1, 0, 0);
    chk(stalls == 0, "R3 no pause across buffers", stalls, 0);
    // R4: single word and short final buffer
    run_op(1, 1, 0, 0, -1, 0, 0);
    run_op(33, 2, 0, 0, -1, 0, -1);
    // R7: one overrun despite several revolutions
    run_op(96, 0, 1, 0, -1, 0, 1);
    chk(stalls == 1, "R7 one stall occurrence", stalls, 1);
    // R5: immediate parity interrupt
    irq_hold = 1;
    run_op(4, 0, 0, 0, 1, 0, 0);
    // R11: start during a read
    run_op(70, 3, 0, 0, -1, 1, -1);
    // R6/R9: random mixes
    for (int i = 0; i < 12; i++) begin
      run_op(1 + int'($urandom % 130), int'($urandom % 7), 0,
             (i % 2) ? 3 : 0, -1, 0, -1);
    end
    // R8: saturation, then cleared on next start
    run_op(262 * 32, 0, 1, 0, -1, 0, 255);
    chk(stalls > 255, "R8 enough stalls to saturate", stalls, 256);
    run_op(40, 0, 0, 0, -1, 0, 0);
    finish_bench();
  end
endmodule